// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block is the byte-wide register interface that a host processor uses to run three independent 16-bit down-counting timer channels. The host sees four byte registers. Three are per-channel data ports and one is a shared control port. The byte address of each register is its two-bit index shifted left by the parameter `ADDR_SHIFT`, so the block can sit on buses whose registers are spaced 1, 2, 4 or more bytes apart.

Control words written to the control port do one of three things: program a channel, latch a channel's running count, or issue a read-back command that snapshots count and/or status for any set of channels. Sixteen-bit counts move through the data ports one or two bytes at a time, following the access mode set for the channel. Each channel has a down-counter that takes its new count on the first counter tick (`cnt_tick`) after the count is complete. The counter runs as a rate generator or as a square-wave generator. Other counting modes are stored and reported but hold the count. The BCD flag is stored only.

The host bus is a plain single-cycle strobe interface with no back-pressure. A write is taken on the clock edge where `wr_en` is high. A read returns `rdata` combinationally while `rd_en` is high, and its side effects (byte pointer advance, latch release) happen on that edge. `rd_en` is ignored while `wr_en` is high.

Top module: `itimer_host_regs`

## Requirements
- R1: The register index is `addr >> ADDR_SHIFT`. Indices 0 to 2 are the data ports of channels 0 to 2 and index 3 is the control port. An address whose low `ADDR_SHIFT` bits are not zero selects nothing: writes to it are ignored and reads of it return 0x00. `rdata` is 0x00 whenever no data-port read is active.
- R2: Control word fields are: bits 7:6 channel (3 = read-back command), bits 5:4 access (01 low byte only, 10 high byte only, 11 low then high, 00 = count latch), bits 3:1 counting mode (6 and 7 act as 2 and 3), and bit 0 BCD (stored only). A programming word stops the channel, sets its null-count flag, clears any held latch and resets both byte pointers. The channel output goes high.
- R3: In low-then-high access, two data writes form the count: the low byte first, then the high byte. In a single-byte access, one write completes the count and the other byte becomes 0.
- R4: A completed count loads into the counter on the next `cnt_tick`, and the null-count flag clears on that tick. A count of 0 means 65536, and a loaded count of 65536 reads back as 0x0000.
- R5: Mode 2 with count N: the output is low for exactly one tick when the counter reaches 1. On the next tick the counter reloads N, giving a period of N ticks.
- R6: Mode 3 with count N: the output is high for ceil(N/2) ticks and low for floor(N/2) ticks. The count steps down by one per tick from N to 1.
- R7: Writing a count of 1 in mode 2 or 3 sets the channel's `cnt_bad` bit and stops the channel, with the output high and the null-count flag set. `cnt_bad` clears on the next legal count or the next programming word for that channel.
- R8: A count-latch word snapshots the current count. Later reads return the snapshot bytes in the access order, and the snapshot is released once its last byte is read.
- R9: While a count snapshot is held, further count-latch commands for that channel are ignored.
- R10: A read-back word (bits 7:6 = 11) selects channels with bit 1 for channel 0, bit 2 for channel 1 and bit 3 for channel 2. A 0 in bit 5 latches the count and a 0 in bit 4 latches the status. A held status byte is returned by the next data read of that channel, before any count byte.
- R11: The status byte is {output level, null-count flag, control bits 5:0 last programmed}. After reset it is 0xC0.
- R12: With no snapshot held, data reads return the live count, and in low-then-high access the byte pointer toggles on each read.
- R13: In modes 0, 1, 4 and 5 a written count is loaded but the counter does not decrement, and the output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counter clock enable, one pulse per count step |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_SHIFT+2 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid while `rd_en` is high |
| ch_out | output | 3 | Channel output levels |
| cnt_bad | output | 3 | Illegal-count flag per channel |

## Verification
The counter function is driven with a rate-generator count of 4 and a square-wave count of 5, so an even period with a single-tick low phase can be told apart from an odd split that must round the high half up. Counts of 0x0123, 0 and single-byte values separate the byte order and the 65536 case from a plain 16-bit load. Latch, repeated latch and read-back sequences, with ticks placed between command and read, show whether the snapshot or the live count reaches the bus. Illegal count 1 in both periodic modes, a misaligned address and non-periodic modes check that these inputs leave the outputs and the status unchanged.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  localparam int NCH   = 3;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    logic prog;
    logic latch_cnt;
    logic latch_sts;
  } ch_cmd_t;

  function automatic logic mode_periodic(input logic [2:0] m);
    return m[1];
  endfunction

  function automatic logic mode_square(input logic [2:0] m);
    return m[1] & m[0];
  endfunction

endpackage

// File: rtl/itimer_decode.sv
module itimer_decode
  import itimer_pkg::*;
#(
  parameter int ADDR_SHIFT = 2
) (
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_SHIFT+1:0] addr,
  input  logic [7:0]            wdata,
  output ch_cmd_t [NCH-1:0]     cmd,
  output logic [NCH-1:0]        data_wr,
  output logic [NCH-1:0]        data_rd
);

  localparam int ADDR_W = ADDR_SHIFT + 2;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ADDR_SHIFT) - 1);
  localparam logic [1:0] IDX_CTRL = 2'd3;

  logic       hit;
  logic [1:0] idx;
  logic       ctrl_wr;
  logic       is_rb;

  assign hit     = (addr & LOW_MASK) == '0;
  assign idx     = 2'(addr >> ADDR_SHIFT);
  assign ctrl_wr = wr_en && hit && (idx == IDX_CTRL);
  assign is_rb   = wdata[7:6] == 2'b11;

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    logic sel_ch;
    logic rb_sel;
    assign sel_ch = wdata[7:6] == 2'(g);
    assign rb_sel = is_rb && wdata[1+g];

    assign cmd[g].prog      = ctrl_wr && sel_ch && (wdata[5:4] != ACC_LATCH);
    assign cmd[g].latch_cnt = ctrl_wr && ((sel_ch && (wdata[5:4] == ACC_LATCH)) ||
                                          (rb_sel && !wdata[5]));
    assign cmd[g].latch_sts = ctrl_wr && rb_sel && !wdata[4];

    assign data_wr[g] = wr_en && hit && (idx == 2'(g));
    assign data_rd[g] = rd_en && !wr_en && hit && (idx == 2'(g));
  end

endmodule

// File: rtl/itimer_chan_regs.sv
module itimer_chan_regs
  import itimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ch_cmd_t          cmd,
  input  logic [5:0]       ctrl_in,
  input  logic             wr,
  input  logic             rd,
  input  logic [7:0]       wdata,
  input  logic [CNT_W-1:0] live_cnt,
  input  logic             out_lvl,
  input  logic             loaded,
  output logic [7:0]       rd_byte,
  output logic [CNT_W-1:0] load_val,
  output logic [2:0]       mode,
  output logic             load_req,
  output logic             stop,
  output logic             bad,
  output logic             null_cnt
);

  logic [5:0]       ctrl_q;
  logic [7:0]       lo_q;
  logic             wr_hi_q;
  logic             rd_hi_q;
  logic             cnt_held_q;
  logic [CNT_W-1:0] held_q;
  logic             sts_held_q;
  logic [7:0]       sts_q;
  acc_e             acc;

  logic             wr_done;
  logic [CNT_W-1:0] new_cr;
  logic             illegal;
  logic [CNT_W-1:0] src;
  logic             rd_last;

  assign acc  = acc_e'(ctrl_q[5:4]);
  assign mode = ctrl_q[3:1];

  // write byte sequencing
  always_comb begin
    wr_done = 1'b0;
    new_cr  = '0;
    unique case (acc)
      ACC_LO:   begin wr_done = wr;            new_cr = {8'h00, wdata}; end
      ACC_HI:   begin wr_done = wr;            new_cr = {wdata, 8'h00}; end
      ACC_LOHI: begin wr_done = wr && wr_hi_q; new_cr = {wdata, lo_q};  end
      default:  begin wr_done = 1'b0;          new_cr = '0;             end
    endcase
  end

  assign illegal = mode_periodic(mode) && (new_cr == CNT_W'(1));
  assign stop    = cmd.prog || (wr_done && illegal);

  // read byte selection
  assign src = cnt_held_q ? held_q : live_cnt;

  always_comb begin
    rd_byte = 8'h00;
    rd_last = 1'b0;
    if (sts_held_q) begin
      rd_byte = sts_q;
    end else begin
      unique case (acc)
        ACC_LO:   begin rd_byte = src[7:0];  rd_last = 1'b1; end
        ACC_HI:   begin rd_byte = src[15:8]; rd_last = 1'b1; end
        ACC_LOHI: begin
          rd_byte = rd_hi_q ? src[15:8] : src[7:0];
          rd_last = rd_hi_q;
        end
        default:  begin rd_byte = 8'h00; rd_last = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      lo_q       <= '0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      cnt_held_q <= 1'b0;
      held_q     <= '0;
      sts_held_q <= 1'b0;
      sts_q      <= '0;
      load_val   <= '0;
      load_req   <= 1'b0;
      bad        <= 1'b0;
      null_cnt   <= 1'b1;
    end else begin
      if (loaded) begin
        load_req <= 1'b0;
        null_cnt <= 1'b0;
      end

      if (cmd.prog) begin
        ctrl_q     <= ctrl_in;
        wr_hi_q    <= 1'b0;
        rd_hi_q    <= 1'b0;
        cnt_held_q <= 1'b0;
        sts_held_q <= 1'b0;
        load_req   <= 1'b0;
        bad        <= 1'b0;
        null_cnt   <= 1'b1;
      end else begin
        if (cmd.latch_cnt && !cnt_held_q) begin
          cnt_held_q <= 1'b1;
          held_q     <= live_cnt;
        end
        if (cmd.latch_sts && !sts_held_q) begin
          sts_held_q <= 1'b1;
          sts_q      <= {out_lvl, null_cnt, ctrl_q};
        end

        if (wr && (acc == ACC_LOHI)) begin
          wr_hi_q <= !wr_hi_q;
          if (!wr_hi_q) lo_q <= wdata;
        end
        if (wr_done) begin
          null_cnt <= 1'b1;
          if (illegal) begin
            bad      <= 1'b1;
            load_req <= 1'b0;
          end else begin
            bad      <= 1'b0;
            load_val <= new_cr;
            load_req <= 1'b1;
          end
        end

        if (rd) begin
          if (sts_held_q) begin
            sts_held_q <= 1'b0;
          end else begin
            if (acc == ACC_LOHI) rd_hi_q <= !rd_hi_q;
            if (rd_last) cnt_held_q <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/itimer_downcnt.sv
module itimer_downcnt
  import itimer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stop,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       mode,
  output logic             loaded,
  output logic             out_lvl,
  output logic             running,
  output logic [CNT_W-1:0] count
);

  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] ce_q;
  logic [EXT_W-1:0] run_n_q;
  logic [EXT_W-1:0] n_ext;
  logic [EXT_W-1:0] nxt;

  assign n_ext  = (load_val == '0) ? (EXT_W'(1) << CNT_W) : {1'b0, load_val};
  assign nxt    = (ce_q == EXT_W'(1)) ? run_n_q : (ce_q - EXT_W'(1));
  assign loaded = tick && load_req && !stop;
  assign count  = ce_q[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q    <= '0;
      run_n_q <= '0;
      running <= 1'b0;
      out_lvl <= 1'b1;
    end else if (stop) begin
      running <= 1'b0;
      out_lvl <= 1'b1;
    end else if (loaded) begin
      ce_q    <= n_ext;
      run_n_q <= n_ext;
      running <= mode_periodic(mode);
      out_lvl <= 1'b1;
    end else if (tick && running) begin
      ce_q    <= nxt;
      out_lvl <= mode_square(mode) ? (nxt > (run_n_q >> 1)) : (nxt != EXT_W'(1));
    end
  end

endmodule

// File: rtl/itimer_host_regs.sv
module itimer_host_regs
  import itimer_pkg::*;
#(
  parameter int ADDR_SHIFT = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_tick,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_SHIFT+1:0] addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic [NCH-1:0]        ch_out,
  output logic [NCH-1:0]        cnt_bad
);

  ch_cmd_t [NCH-1:0] cmd;
  logic [NCH-1:0]    data_wr;
  logic [NCH-1:0]    data_rd;
  logic [7:0]        ch_byte [NCH];
  logic [NCH-1:0]    null_v;
  logic [NCH-1:0]    run_v;
  logic [3*NCH-1:0]  mode_v;

  itimer_decode #(.ADDR_SHIFT(ADDR_SHIFT)) u_dec (
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .cmd     (cmd),
    .data_wr (data_wr),
    .data_rd (data_rd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] load_val;
    logic [2:0]       mode;
    logic             load_req;
    logic             stop;
    logic             loaded;

    itimer_chan_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd[g]),
      .ctrl_in  (wdata[5:0]),
      .wr       (data_wr[g]),
      .rd       (data_rd[g]),
      .wdata    (wdata),
      .live_cnt (live_cnt),
      .out_lvl  (ch_out[g]),
      .loaded   (loaded),
      .rd_byte  (ch_byte[g]),
      .load_val (load_val),
      .mode     (mode),
      .load_req (load_req),
      .stop     (stop),
      .bad      (cnt_bad[g]),
      .null_cnt (null_v[g])
    );

    itimer_downcnt u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (cnt_tick),
      .stop     (stop),
      .load_req (load_req),
      .load_val (load_val),
      .mode     (mode),
      .loaded   (loaded),
      .out_lvl  (ch_out[g]),
      .running  (run_v[g]),
      .count    (live_cnt)
    );

    assign mode_v[3*g +: 3] = mode;
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NCH; i++) begin
      if (data_rd[i]) rdata = rdata | ch_byte[i];
    end
  end

endmodule

// File: rtl/itimer_host_regs_chk.sv
module itimer_host_regs_chk #(
  parameter int NCH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_tick,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       rdata,
  input logic [NCH-1:0]   ch_out,
  input logic [NCH-1:0]   cnt_bad,
  input logic [NCH-1:0]   null_v,
  input logic [NCH-1:0]   run_v,
  input logic [3*NCH-1:0] mode_v
);

  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic rate;
    assign rate = mode_v[3*g+1] && !mode_v[3*g];

    assert_null_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(null_v[g]) |-> $past(cnt_tick));

    assert_low_one_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[g] && rate && !ch_out[g] && cnt_tick) |=> ch_out[g]);

    assert_out_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_tick && !wr_en) |=> $stable(ch_out[g]));

    assert_bad_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_bad[g] |-> (!run_v[g] && ch_out[g] && null_v[g]));

    assert_idle_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !run_v[g] |-> ch_out[g]);
  end

endmodule

bind itimer_host_regs itimer_host_regs_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_tick (cnt_tick),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .ch_out   (ch_out),
  .cnt_bad  (cnt_bad),
  .null_v   (null_v),
  .run_v    (run_v),
  .mode_v   (mode_v)
);

// File: tb/tb_itimer_host_regs.sv
module tb_itimer_host_regs;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cnt_tick;
  logic       wr_en;
  logic       rd_en;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [2:0] ch_out;
  logic [2:0] cnt_bad;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  itimer_host_regs #(.ADDR_SHIFT(2)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_tick (cnt_tick),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .ch_out   (ch_out),
    .cnt_bad  (cnt_bad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_out(input bit sq, input int n, input int k);
    int ce;
    ce = n - (k % n);
    return sq ? (ce > n / 2) : (ce != 1);
  endfunction

  task automatic wr_raw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    wr_raw(4'(idx << 2), d);
  endtask

  task automatic rd_raw(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [7:0] d);
    rd_raw(4'(idx << 2), d);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_tick = 1'b1;
      @(negedge clk);
      cnt_tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 reset outputs high", ch_out, 3'b111);
    chk("R7 reset no bad flag", cnt_bad, 3'b000);
    wr(3, 8'hE2); rd(0, d);
    chk("R11 reset status ch0", d, 8'hC0);
    wr(3, 8'hE8); rd(2, d);
    chk("R10 reset status ch2", d, 8'hC0);
  endtask

  task automatic t_rate();
    logic [7:0] d;
    wr(3, 8'h34); wr(0, 8'h04); wr(0, 8'h00);
    wr(3, 8'hE2); rd(0, d);
    chk("R2 R11 status before load", d, 8'hF4);
    for (int j = 1; j <= 9; j++) begin
      tick(1);
      chk("R5 rate output", ch_out[0], exp_out(0, 4, j - 1));
    end
    wr(3, 8'hE2); rd(0, d);
    chk("R4 null cleared after load", d, 8'hB4);
  endtask

  task automatic t_square();
    wr(3, 8'h76); wr(1, 8'h05); wr(1, 8'h00);
    for (int j = 1; j <= 10; j++) begin
      tick(1);
      chk("R6 square output", ch_out[1], exp_out(1, 5, j - 1));
    end
  endtask

  task automatic t_latch();
    logic [7:0] d;
    wr(3, 8'h34); wr(0, 8'h23); wr(0, 8'h01);
    tick(6);
    wr(3, 8'h00);
    tick(3);
    rd(0, d); chk("R8 latched low", d, 8'h1E);
    rd(0, d); chk("R3 R8 latched high", d, 8'h01);
    wr(3, 8'h00);
    tick(2);
    wr(3, 8'h00);
    rd(0, d); chk("R9 second latch ignored low", d, 8'h1B);
    rd(0, d); chk("R9 second latch ignored high", d, 8'h01);
    rd(0, d); chk("R12 live low", d, 8'h19);
    rd(0, d); chk("R12 live high", d, 8'h01);
  endtask

  task automatic t_illegal();
    logic [7:0] d;
    wr(3, 8'hB4); wr(2, 8'h01); wr(2, 8'h00);
    chk("R7 bad set mode 2", cnt_bad[2], 1'b1);
    tick(3);
    chk("R7 output stays high", ch_out[2], 1'b1);
    wr(3, 8'hE8); rd(2, d);
    chk("R7 status null kept", d, 8'hF4);
    wr(2, 8'h02); wr(2, 8'h00);
    chk("R7 bad cleared by legal count", cnt_bad[2], 1'b0);
    wr(3, 8'hB6); wr(2, 8'h01); wr(2, 8'h00);
    chk("R7 bad set mode 3", cnt_bad[2], 1'b1);
    wr(3, 8'hB6);
    chk("R7 bad cleared by control", cnt_bad[2], 1'b0);
  endtask

  task automatic t_zero();
    logic [7:0] d;
    wr(3, 8'hB4); wr(2, 8'h00); wr(2, 8'h00);
    tick(1);
    wr(3, 8'h80);
    rd(2, d); chk("R4 zero count low", d, 8'h00);
    rd(2, d); chk("R4 zero count high", d, 8'h00);
    tick(1);
    wr(3, 8'h80);
    rd(2, d); chk("R4 65535 low", d, 8'hFF);
    rd(2, d); chk("R4 65535 high", d, 8'hFF);
  endtask

  task automatic t_single();
    logic [7:0] d;
    wr(3, 8'h94); wr(2, 8'h05);
    tick(1);
    rd(2, d); chk("R3 low-only load", d, 8'h05);
    tick(1);
    rd(2, d); chk("R12 low-only live", d, 8'h04);
    wr(3, 8'hA4); wr(2, 8'h01);
    tick(1);
    rd(2, d); chk("R3 high-only load", d, 8'h01);
    tick(1);
    rd(2, d); chk("R12 high-only live", d, 8'h00);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(3, 8'h74); wr(1, 8'h34); wr(1, 8'h12);
    tick(1);
    wr(3, 8'hC4);
    tick(2);
    rd(1, d); chk("R10 R11 status first", d, 8'hB4);
    rd(1, d); chk("R10 count low", d, 8'h34);
    rd(1, d); chk("R10 count high", d, 8'h12);
  endtask

  task automatic t_other();
    logic [7:0] d;
    wr(3, 8'h70); wr(1, 8'h10); wr(1, 8'h00);
    tick(4);
    chk("R13 output high in mode 0", ch_out[1], 1'b1);
    rd(1, d); chk("R13 count held low", d, 8'h10);
    rd(1, d); chk("R13 count held high", d, 8'h00);
    wr(3, 8'h7C); wr(1, 8'h03); wr(1, 8'h00);
    tick(3);
    chk("R2 mode 6 acts as rate", ch_out[1], 1'b0);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    wr_raw(4'hD, 8'h70);
    wr(3, 8'hE2); rd(0, d);
    chk("R1 misaligned write ignored", d & 8'h3F, 8'h34);
    rd_raw(4'h1, d);
    chk("R1 misaligned read zero", d, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate();
    t_square();
    t_latch();
    t_illegal();
    t_zero();
    t_single();
    t_readback();
    t_other();
    t_decode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule